// File: doc/BRIEF.md
# Combined Program and Swallow Counter for a Dual-Modulus Divider

This block replaces the two counters of a pulse-swallow frequency divider with a single programmable down counter. It runs on the output of a dual-modulus prescaler. Each division period is P prescaler cycles long. For the first S cycles of the period it holds the modulus-control output low. For the remaining P−S cycles it holds it high. Once per period it emits a one-cycle divided-output pulse.

The swallow count is never presented to the block. The surrounding logic supplies the load value P and the difference D = P − S. An equality compare between the next count and the latched D raises the modulus flag. A zero detector on the count is the common reload. That reload restarts the count from P, latches a new D and lowers the flag.

Load and difference values are sampled only when the counter reloads, and at reset, so software or a sigma-delta modulator can change them at any time without tearing a period. All outputs are registered.

Top module: `pswc_top`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads `load_val`, latches `diff_val` and clears `div_pulse`. `mod_ctl` takes 1 if `load_val` equals `diff_val` and 0 otherwise. No divided pulse marks the period that this load starts.
- R2: After a load with value P ≥ 2, the period lasts exactly P cycles. The next period starts with a reload on the P-th rising edge after the load.
- R3: Let cycle k (k = 0 … P−1) be the k-th cycle of a period loaded with P and D, and let S = P − D. When D ≤ P, `mod_ctl` is 0 for k < S and 1 for k ≥ S. This matches a separate swallow counter (limit S) and program counter (limit P) running side by side. When D > P, `mod_ctl` stays 0 for the whole period.
- R4: `div_pulse` is 1 in cycle k = 0 of every period begun by a reload, and 0 in every other cycle.
- R5: `load_val` and `diff_val` are sampled only at a reload edge or a reset edge. A change during a period does not alter that period's length or flag pattern. It takes effect from the next period.
- R6: A load value of 0 or 1 gives a period of one cycle, so `div_pulse` stays 1 after the first reload. In that case `mod_ctl` is 1 exactly when D ≤ P and S = P − D is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, used as the clock |
| rst | input | 1 | Synchronous active-high reset |
| load_val | input | WIDTH | Program count P |
| diff_val | input | WIDTH | Precomputed difference D = P − S |
| mod_ctl | output | 1 | Modulus-control flag to the prescaler |
| div_pulse | output | 1 | Divided output, one cycle high per period |

## Verification
Both outputs are registered. The value belonging to position k of a period is therefore present from the rising edge that enters that position. A new load value first shows up in the cycle after the reload edge that samples it. The bench advances its reference counters right after each rising edge, using the inputs it drove at the previous falling edge. It compares `mod_ctl` and `div_pulse` at the following falling edge. Operands are also changed at falling edges in the middle of periods, so the sampling rule of R5 is checked in the same cycle-exact way.

// File: rtl/pswc_pkg.sv
package pswc_pkg;
  // Default counter width; the block needs at least 2 bits.
  localparam int PSWC_DEF_WIDTH = 6;
endpackage

// File: rtl/pswc_zero_det.sv
// Reload detector: true when the count is 0 or 1 (all upper bits clear),
// so the decrement about to happen would land on zero.
module pswc_zero_det #(
  parameter int HI_W = 5
) (
  input  logic [HI_W-1:0] hi_bits,
  output logic            reload_o
);
  logic [HI_W-1:0] any_set;

  assign any_set[0] = hi_bits[0];
  for (genvar i = 1; i < HI_W; i++) begin : g_or_chain
    assign any_set[i] = any_set[i-1] | hi_bits[i];
  end

  assign reload_o = ~any_set[HI_W-1];
endmodule

// File: rtl/pswc_eq_cmp.sv
// Bitwise equality comparator.
module pswc_eq_cmp #(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             eq_o
);
  logic [WIDTH-1:0] bit_same;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bits
    assign bit_same[i] = ~(a_i[i] ^ b_i[i]);
  end

  assign eq_o = &bit_same;
endmodule

// File: rtl/pswc_downcnt.sv
// Down counter with operand latch; reset behaves as a reload.
module pswc_downcnt #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload_i,
  input  logic [WIDTH-1:0] load_i,
  input  logic [WIDTH-1:0] diff_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] nxt_o,
  output logic [WIDTH-1:0] dlat_o
);
  assign nxt_o = cnt_o - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || reload_i) begin
      cnt_o  <= load_i;
      dlat_o <= diff_i;
    end else begin
      cnt_o  <= nxt_o;
    end
  end

  // R2: count steps down by one when not reloading
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    !reload_i |=> (cnt_o == $past(cnt_o) - 1'b1));

  // R5: operands captured exactly at the reload edge
  p_reload_sample_r5: assert property (@(posedge clk) disable iff (rst)
    reload_i |=> (cnt_o == $past(load_i) && dlat_o == $past(diff_i)));

  // R5: latched difference frozen inside a period
  p_diff_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !reload_i |=> $stable(dlat_o));
endmodule

// File: rtl/pswc_flag.sv
// Modulus-control flop and divided-output pulse flop.
module pswc_flag (
  input  logic clk,
  input  logic rst,
  input  logic reload_i,
  input  logic hit_i,
  input  logic start_hi_i,
  output logic mod_o,
  output logic pulse_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mod_o   <= start_hi_i;
      pulse_o <= 1'b0;
    end else if (reload_i) begin
      mod_o   <= start_hi_i;
      pulse_o <= 1'b1;
    end else begin
      if (hit_i) mod_o <= 1'b1;
      pulse_o <= 1'b0;
    end
  end

  // R3: once high the flag holds until the next reload
  p_flag_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!reload_i && mod_o) |=> mod_o);

  // R4: a pulse follows each reload edge
  p_pulse_on_reload_r4: assert property (@(posedge clk) disable iff (rst)
    reload_i |=> pulse_o);

  // R4: no pulse when the counter only stepped
  p_pulse_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !reload_i |=> !pulse_o);
endmodule

// File: rtl/pswc_top.sv
module pswc_top #(
  parameter int WIDTH = pswc_pkg::PSWC_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] diff_val,
  output logic             mod_ctl,
  output logic             div_pulse
);
  localparam int HI_W = WIDTH - 1;

  logic [WIDTH-1:0] cnt_w;
  logic [WIDTH-1:0] nxt_w;
  logic [WIDTH-1:0] dlat_w;
  logic             reload_w;
  logic             hit_w;
  logic             start_hi_w;

  pswc_downcnt #(.WIDTH(WIDTH)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .reload_i (reload_w),
    .load_i   (load_val),
    .diff_i   (diff_val),
    .cnt_o    (cnt_w),
    .nxt_o    (nxt_w),
    .dlat_o   (dlat_w)
  );

  pswc_zero_det #(.HI_W(HI_W)) u_zero (
    .hi_bits  (cnt_w[WIDTH-1:1]),
    .reload_o (reload_w)
  );

  // Next count against the latched difference: flag rises as count reaches D.
  pswc_eq_cmp #(.WIDTH(WIDTH)) u_cmp_run (
    .a_i  (nxt_w),
    .b_i  (dlat_w),
    .eq_o (hit_w)
  );

  // New operands equal: S is zero, flag starts the period high.
  pswc_eq_cmp #(.WIDTH(WIDTH)) u_cmp_start (
    .a_i  (load_val),
    .b_i  (diff_val),
    .eq_o (start_hi_w)
  );

  pswc_flag u_flag (
    .clk        (clk),
    .rst        (rst),
    .reload_i   (reload_w),
    .hit_i      (hit_w),
    .start_hi_i (start_hi_w),
    .mod_o      (mod_ctl),
    .pulse_o    (div_pulse)
  );

  // R3: a rise of the flag inside a period happens only where count equals D
  p_rise_at_match_r3: assert property (@(posedge clk) disable iff (rst)
    (!div_pulse && $rose(mod_ctl)) |-> (cnt_w == dlat_w));

  // R6: a count of 0 or 1 always reloads on the next edge
  p_short_period_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_w <= 1) |=> div_pulse);
endmodule

// File: tb/pswc_top_tb_top.sv
`timescale 1ns/1ps
module pswc_top_tb_top;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] p_drv = '0;
  logic [W-1:0] d_drv = '0;
  logic         mod_ctl;
  logic         div_pulse;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;

  // reference: program position k, latched P and D
  int  k_pos = 0;
  int  pm = 0;
  int  dm = 0;
  bit  exp_pulse = 0;

  always #5 clk = ~clk;

  pswc_top #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .load_val  (p_drv),
    .diff_val  (d_drv),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse)
  );

  function automatic bit exp_mod(int k, int p, int d);
    // swallow counter counts S = P - D cycles, then the flag is high
    if (d > p) return 1'b0;
    return (k >= (p - d));
  endfunction

  function automatic int period_len(int p);
    return (p <= 1) ? 1 : p;
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d expected %0d (P=%0d D=%0d k=%0d)",
               tag, what, got, exp, pm, dm, k_pos);
    end
  endtask

  // one clock: advance the model after the rising edge, compare at falling edge
  task automatic step();
    string tm, tp;
    @(posedge clk);
    if (rst) begin
      pm = int'(p_drv); dm = int'(d_drv); k_pos = 0; exp_pulse = 0;
    end else if (k_pos >= period_len(pm) - 1) begin
      pm = int'(p_drv); dm = int'(d_drv); k_pos = 0; exp_pulse = 1;
    end else begin
      k_pos++; exp_pulse = 0;
    end
    @(negedge clk);
    if (pm <= 1) begin
      tm = "R6"; tp = "R6";
    end else begin
      tm = (int'(p_drv) != pm || int'(d_drv) != dm) ? "R5" : "R3";
      tp = (k_pos == 0) ? "R4" : "R2";
    end
    check(tm, "mod_ctl", int'(mod_ctl), int'(exp_mod(k_pos, pm, dm)));
    check(tp, "div_pulse", int'(div_pulse), int'(exp_pulse));
  endtask

  task automatic run_set(int p, int d, int cycles);
    p_drv = W'(p); d_drv = W'(d);
    for (int i = 0; i < cycles; i++) step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    // R1: reset state, P=7 D=3
    rst = 1'b1; p_drv = 6'd7; d_drv = 6'd3;
    step(); step();
    check("R1", "reset mod_ctl", int'(mod_ctl), 0);
    check("R1", "reset div_pulse", int'(div_pulse), 0);
    @(negedge clk); rst = 1'b0;
    // R3: P=7 S=4 pattern 0000111, three periods
    run_set(7, 3, 21);
    // R3: S=0 (flag high all period), S=P (flag low), D>P (flag low)
    run_set(9, 9, 18);
    run_set(5, 0, 15);
    run_set(4, 10, 12);
    // R2: long period at full width
    run_set(63, 62, 130);
    // R6: one-cycle periods
    run_set(1, 0, 4);
    run_set(1, 1, 4);
    run_set(0, 0, 4);
    run_set(0, 3, 4);
    // R5: change operands mid period
    run_set(12, 5, 4);
    run_set(3, 1, 30);
    // R1: reset in mid period with equal operands
    p_drv = 6'd8; d_drv = 6'd8; rst = 1'b1;
    step();
    check("R1", "reset mod_ctl equal", int'(mod_ctl), 1);
    check("R1", "reset div_pulse equal", int'(div_pulse), 0);
    rst = 1'b0;
    run_set(8, 8, 10);
    // random mix, mostly P > S, with mid-period changes and occasional reset
    for (int s = 0; s < 60; s++) begin
      int p, d, len;
      p = int'($urandom_range(63, 2));
      d = int'($urandom_range(p, 0));
      if ($urandom_range(9, 0) == 0) d = int'($urandom_range(63, 0));
      if ($urandom_range(14, 0) == 0) p = int'($urandom_range(1, 0));
      len = int'($urandom_range(150, 1));
      if ($urandom_range(19, 0) == 0) begin
        rst = 1'b1; p_drv = W'(p); d_drv = W'(d);
        step();
        rst = 1'b0;
      end
      run_set(p, d, len);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule